// File: doc/BRIEF.md
# Card DMA Handshake Signal Remapper

This block lets a host DMA engine talk to a card socket that has no pins set aside for DMA. The remapper borrows pins the socket already has. A 2-bit select field names which of three card status inputs carries the card's active-low DMA request. That level is synchronized and presented to the host as an active-high request. The socket's register-select, read-strobe and write-strobe outputs are redefined for the length of each DMA data cycle. Register-select goes high and acts as the acknowledge. One of the two strobes carries an active-low terminal count, chosen by the direction of the transfer.

No separate acknowledge phase exists. The card must take its first DMA data cycle as the grant. Redefinition only happens while the socket is in I/O card mode. The block also switches off the normal use of whichever pin it borrows: the 16-bit auto-size enables, the audio/LED output, or the input-acknowledge control. When the 16-bit indicator pin carries the request, a status bit shows that pin's live level.

A change to the select field is deferred until the current DMA data cycle has ended. Every interface here is a plain level or strobe. The block has no streaming data path, so it has no valid/ready flow control.

Top module: `dma_pin_remap`

## Requirements
- R1: The select field `cfg_req_sel` encodes the request source: 2'b10 selects `card_width_n`, 2'b11 selects `card_audio_n`, 2'b01 selects `card_inack_n`, and 2'b00 disables DMA. The selected pin is active-low. `host_dreq` is high exactly when that pin was low, with a delay of two clock edges through a synchronizer.
- R2: `host_dreq` stays low while the effective select is 2'b00 or `cfg_io_mode` is low, whatever the card pins do.
- R3: A DMA data cycle is in progress when all of these hold: the effective select is non-zero, `cfg_io_mode` is high, `host_dack` is high, and at least one of `host_ior_n` and `host_iow_n` is low. During such a cycle `card_regsel_n` is driven 1. At all other times it follows `std_reg_n`.
- R4: During a DMA data cycle with `host_ior_n` low, `card_rdstb_n` equals the inverse of `host_tc`. Otherwise it follows `std_oe_n`.
- R5: During a DMA data cycle with `host_iow_n` low, `card_wrstb_n` equals the inverse of `host_tc`. Otherwise it follows `std_we_n`.
- R6: Outside a DMA data cycle, `host_tc` has no effect on any card output. This holds when `host_dack` is low, when both strobes are high, when the select is 2'b00, and when `cfg_io_mode` is low.
- R7: While the effective select is 2'b10, `stat4` shows the raw level of `card_width_n` and every bit of `auto16_eff` is 0. For any other select, `stat4` follows `std_stat4` and `auto16_eff` follows `std_auto16`.
- R8: While the effective select is 2'b11, `card_audio_out` is 0. Otherwise it follows `std_audio`.
- R9: While the effective select is 2'b01, `inack_ctl_eff` is 0. Otherwise it follows `std_inack_ctl`.
- R10: The effective select loads `cfg_req_sel` on each clock edge at which no DMA data cycle is in progress, and holds its value on edges during a cycle. A change made mid-cycle therefore takes effect on the first edge after the cycle ends.
- R11: While `rst_n` is low, the effective select is 2'b00 and `host_dreq` is 0. The synchronizer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req_sel | input | 2 | Request source select field |
| cfg_io_mode | input | 1 | Socket is in I/O card mode |
| card_width_n | input | 1 | Card 16-bit indicator pin |
| card_audio_n | input | 1 | Card audio/LED pin |
| card_inack_n | input | 1 | Card input-acknowledge pin |
| host_dack | input | 1 | Host DMA acknowledge, active-high |
| host_tc | input | 1 | Host terminal count, active-high |
| host_ior_n | input | 1 | Host I/O read strobe, active-low |
| host_iow_n | input | 1 | Host I/O write strobe, active-low |
| std_reg_n | input | 1 | Normal register-select value |
| std_oe_n | input | 1 | Normal output-enable value |
| std_we_n | input | 1 | Normal write-enable value |
| std_audio | input | 1 | Normal audio/LED output value |
| std_auto16 | input | NWIN | Normal 16-bit auto-size enable per I/O window |
| std_inack_ctl | input | 1 | Normal input-acknowledge control enable |
| std_stat4 | input | 1 | Normal value of status bit 4 |
| host_dreq | output | 1 | Synchronized DMA request, active-high |
| card_regsel_n | output | 1 | Register-select pin to card |
| card_rdstb_n | output | 1 | Output-enable pin to card |
| card_wrstb_n | output | 1 | Write-enable pin to card |
| card_audio_out | output | 1 | Gated audio/LED output |
| auto16_eff | output | NWIN | Gated 16-bit auto-size enables |
| inack_ctl_eff | output | 1 | Gated input-acknowledge control |
| stat4 | output | 1 | Status bit 4 |

## Verification
Two things can happen in the same clock cycle. A DMA data cycle can be under way, changing the strobe pins, while the select field is rewritten, which would switch the request source and the pin gating. The bench opens a read-strobe DMA cycle on the 16-bit source and rewrites the select to the audio source in the middle of it. It then checks that the status and audio gating keep their old source and that the acknowledge stays high for as long as the cycle lasts. It also checks that the new source appears on the first edge after the strobes rise. The same hazard appears when read and write strobes are low together: the bench expects terminal count on both strobe pins at once.

// File: rtl/dma_remap_pkg.sv
package dma_remap_pkg;

  // Encoding of the request-source select field; the values are fixed by
  // the control register layout that software programs.
  typedef enum logic [1:0] {
    SRC_OFF    = 2'b00,
    SRC_INACK  = 2'b01,
    SRC_WIDTH  = 2'b10,
    SRC_AUDIO  = 2'b11
  } req_src_e;

  localparam int unsigned SRC_PINS = 3;

  // Index of each card status pin inside the packed pin vector.
  localparam int unsigned PIN_WIDTH = 0;
  localparam int unsigned PIN_AUDIO = 1;
  localparam int unsigned PIN_INACK = 2;

endpackage

// File: rtl/dma_sel_hold.sv
module dma_sel_hold
  import dma_remap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] cfg_sel,
  input  logic     cyc_busy,
  output req_src_e eff_sel
);

  // The effective source only moves on edges with no DMA data cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_sel <= SRC_OFF;
    end else if (!cyc_busy) begin
      eff_sel <= req_src_e'(cfg_sel);
    end
  end

  // R10: source is frozen across an edge that sees an active cycle
  p_sel_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_busy |=> eff_sel == $past(eff_sel));

  // R10: idle edge loads the programmed field
  p_sel_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_busy |=> eff_sel == req_src_e'($past(cfg_sel)));

endmodule

// File: rtl/dma_dreq_sync.sv
module dma_dreq_sync
  import dma_remap_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  req_src_e            eff_sel,
  input  logic                io_mode,
  input  logic [SRC_PINS-1:0] pins_n,
  output logic                host_dreq
);

  localparam int unsigned LAST = STAGES - 1;

  logic dma_on;
  logic raw_req;
  logic [STAGES-1:0] sync_q;

  assign dma_on = io_mode && (eff_sel != SRC_OFF);

  // Active-low source picked by the select field, turned active-high.
  always_comb begin
    unique case (eff_sel)
      SRC_WIDTH: raw_req = ~pins_n[PIN_WIDTH];
      SRC_AUDIO: raw_req = ~pins_n[PIN_AUDIO];
      SRC_INACK: raw_req = ~pins_n[PIN_INACK];
      default:   raw_req = 1'b0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= raw_req & dma_on;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign host_dreq = sync_q[LAST] & dma_on;

  // R1: a request reaching the host was seen low on the chosen pin two edges ago
  p_dreq_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_dreq |-> $past(raw_req & dma_on, 2));

endmodule

// File: rtl/dma_strobe_map.sv
module dma_strobe_map
  import dma_remap_pkg::*;
(
  input  req_src_e eff_sel,
  input  logic     io_mode,
  input  logic     host_dack,
  input  logic     host_tc,
  input  logic     host_ior_n,
  input  logic     host_iow_n,
  input  logic     std_reg_n,
  input  logic     std_oe_n,
  input  logic     std_we_n,
  output logic     cyc_busy,
  output logic     card_regsel_n,
  output logic     card_rdstb_n,
  output logic     card_wrstb_n
);

  logic dma_on;
  logic rd_leg;
  logic wr_leg;

  assign dma_on   = io_mode && (eff_sel != SRC_OFF);
  assign cyc_busy = dma_on && host_dack && (!host_ior_n || !host_iow_n);

  // Read strobe from the host moves data card->memory: TC rides output-enable.
  assign rd_leg = cyc_busy && !host_ior_n;
  // Write strobe from the host moves data memory->card: TC rides write-enable.
  assign wr_leg = cyc_busy && !host_iow_n;

  always_comb begin
    card_regsel_n = cyc_busy ? 1'b1 : std_reg_n;
    card_rdstb_n  = rd_leg ? ~host_tc : std_oe_n;
    card_wrstb_n  = wr_leg ? ~host_tc : std_we_n;
  end

endmodule

// File: rtl/dma_pin_gate.sv
module dma_pin_gate
  import dma_remap_pkg::*;
#(
  parameter int unsigned NWIN = 2
) (
  input  req_src_e         eff_sel,
  input  logic             card_width_n,
  input  logic             std_audio,
  input  logic [NWIN-1:0]  std_auto16,
  input  logic             std_inack_ctl,
  input  logic             std_stat4,
  output logic             card_audio_out,
  output logic [NWIN-1:0]  auto16_eff,
  output logic             inack_ctl_eff,
  output logic             stat4
);

  logic use_width;
  logic use_audio;
  logic use_inack;

  assign use_width = (eff_sel == SRC_WIDTH);
  assign use_audio = (eff_sel == SRC_AUDIO);
  assign use_inack = (eff_sel == SRC_INACK);

  genvar w;
  generate
    for (w = 0; w < NWIN; w++) begin : g_win
      assign auto16_eff[w] = std_auto16[w] & ~use_width;
    end
  endgenerate

  assign card_audio_out = std_audio & ~use_audio;
  assign inack_ctl_eff  = std_inack_ctl & ~use_inack;
  assign stat4          = use_width ? card_width_n : std_stat4;

endmodule

// File: rtl/dma_pin_remap.sv
module dma_pin_remap
  import dma_remap_pkg::*;
#(
  parameter int unsigned NWIN        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_req_sel,
  input  logic            cfg_io_mode,
  input  logic            card_width_n,
  input  logic            card_audio_n,
  input  logic            card_inack_n,
  input  logic            host_dack,
  input  logic            host_tc,
  input  logic            host_ior_n,
  input  logic            host_iow_n,
  input  logic            std_reg_n,
  input  logic            std_oe_n,
  input  logic            std_we_n,
  input  logic            std_audio,
  input  logic [NWIN-1:0] std_auto16,
  input  logic            std_inack_ctl,
  input  logic            std_stat4,
  output logic            host_dreq,
  output logic            card_regsel_n,
  output logic            card_rdstb_n,
  output logic            card_wrstb_n,
  output logic            card_audio_out,
  output logic [NWIN-1:0] auto16_eff,
  output logic            inack_ctl_eff,
  output logic            stat4
);

  req_src_e            eff_sel;
  logic                cyc_busy;
  logic [SRC_PINS-1:0] pins_n;

  assign pins_n[PIN_WIDTH] = card_width_n;
  assign pins_n[PIN_AUDIO] = card_audio_n;
  assign pins_n[PIN_INACK] = card_inack_n;

  dma_sel_hold u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_sel  (cfg_req_sel),
    .cyc_busy (cyc_busy),
    .eff_sel  (eff_sel)
  );

  dma_dreq_sync #(.STAGES(SYNC_STAGES)) u_dreq (
    .clk       (clk),
    .rst_n     (rst_n),
    .eff_sel   (eff_sel),
    .io_mode   (cfg_io_mode),
    .pins_n    (pins_n),
    .host_dreq (host_dreq)
  );

  dma_strobe_map u_strb (
    .eff_sel       (eff_sel),
    .io_mode       (cfg_io_mode),
    .host_dack     (host_dack),
    .host_tc       (host_tc),
    .host_ior_n    (host_ior_n),
    .host_iow_n    (host_iow_n),
    .std_reg_n     (std_reg_n),
    .std_oe_n      (std_oe_n),
    .std_we_n      (std_we_n),
    .cyc_busy      (cyc_busy),
    .card_regsel_n (card_regsel_n),
    .card_rdstb_n  (card_rdstb_n),
    .card_wrstb_n  (card_wrstb_n)
  );

  dma_pin_gate #(.NWIN(NWIN)) u_gate (
    .eff_sel        (eff_sel),
    .card_width_n   (card_width_n),
    .std_audio      (std_audio),
    .std_auto16     (std_auto16),
    .std_inack_ctl  (std_inack_ctl),
    .std_stat4      (std_stat4),
    .card_audio_out (card_audio_out),
    .auto16_eff     (auto16_eff),
    .inack_ctl_eff  (inack_ctl_eff),
    .stat4          (stat4)
  );

  // R2: no request to the host while DMA is off or the socket is in memory mode
  p_dreq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_io_mode || eff_sel == SRC_OFF) |-> !host_dreq);

  // R3: acknowledge is high on the card for every host data strobe of a DMA cycle
  p_ack_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_dack && cfg_io_mode && eff_sel != SRC_OFF && (!host_ior_n || !host_iow_n))
      |-> card_regsel_n);

  // R6: without a host acknowledge the strobes keep their normal values
  p_tc_confined_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_dack |-> (card_rdstb_n == std_oe_n) && (card_wrstb_n == std_we_n)
                   && (card_regsel_n == std_reg_n));

  // R8: a borrowed audio pin never drives the speaker path
  p_audio_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_sel == SRC_AUDIO) |-> !card_audio_out);

  // R11: reset leaves the request low
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |-> !host_dreq);

endmodule

// File: tb/dma_pin_remap_tb_top.sv
module dma_pin_remap_tb_top;

  localparam int NWIN = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_req_sel;
  logic cfg_io_mode;
  logic card_width_n, card_audio_n, card_inack_n;
  logic host_dack, host_tc, host_ior_n, host_iow_n;
  logic std_reg_n, std_oe_n, std_we_n, std_audio, std_inack_ctl, std_stat4;
  logic [NWIN-1:0] std_auto16;
  logic host_dreq, card_regsel_n, card_rdstb_n, card_wrstb_n;
  logic card_audio_out, inack_ctl_eff, stat4;
  logic [NWIN-1:0] auto16_eff;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_pin_remap #(.NWIN(NWIN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_req_sel(cfg_req_sel), .cfg_io_mode(cfg_io_mode),
    .card_width_n(card_width_n), .card_audio_n(card_audio_n), .card_inack_n(card_inack_n),
    .host_dack(host_dack), .host_tc(host_tc), .host_ior_n(host_ior_n), .host_iow_n(host_iow_n),
    .std_reg_n(std_reg_n), .std_oe_n(std_oe_n), .std_we_n(std_we_n), .std_audio(std_audio),
    .std_auto16(std_auto16), .std_inack_ctl(std_inack_ctl), .std_stat4(std_stat4),
    .host_dreq(host_dreq), .card_regsel_n(card_regsel_n), .card_rdstb_n(card_rdstb_n),
    .card_wrstb_n(card_wrstb_n), .card_audio_out(card_audio_out), .auto16_eff(auto16_eff),
    .inack_ctl_eff(inack_ctl_eff), .stat4(stat4)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_host();
    host_dack = 0; host_tc = 0; host_ior_n = 1; host_iow_n = 1;
  endtask

  // Program the field with the host idle so it loads, then let the synchronizer settle.
  task automatic set_cfg(input logic [1:0] s, input logic io);
    @(negedge clk);
    idle_host();
    cfg_req_sel = s; cfg_io_mode = io;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_req_sel = 2'b10; cfg_io_mode = 1;
    card_width_n = 0; card_audio_n = 0; card_inack_n = 0;
    idle_host();
    std_reg_n = 1; std_oe_n = 1; std_we_n = 1; std_audio = 1;
    std_auto16 = '1; std_inack_ctl = 1; std_stat4 = 1;
    repeat (3) @(negedge clk);
    #2;
    // R11: effective select is off during reset, so nothing is gated and no request
    chk(host_dreq == 0, "R11 dreq", host_dreq, 0);
    chk(stat4 == 1 && auto16_eff == '1, "R11 gating", stat4, 1);
    @(negedge clk);
    rst_n = 1;

    // R1, R2: request path over every select, mode and pin pattern
    for (int s = 0; s < 4; s++) begin
      for (int io = 0; io < 2; io++) begin
        set_cfg(s[1:0], io[0]);
        for (int p = 0; p < 8; p++) begin
          logic pl;
          logic ex;
          card_width_n = p[0]; card_audio_n = p[1]; card_inack_n = p[2];
          repeat (3) @(negedge clk);
          #2;
          case (s)
            2: pl = p[0];
            3: pl = p[1];
            1: pl = p[2];
            default: pl = 1'b1;
          endcase
          ex = (io == 1) && (s != 0) && !pl;
          chk(host_dreq == ex, (s == 0 || io == 0) ? "R2 dreq off" : "R1 dreq",
              host_dreq, ex);
        end
        // R1: two-edge synchronizer latency when the selected pin falls
        if (io == 1 && s != 0) begin
          @(negedge clk);
          card_width_n = 1; card_audio_n = 1; card_inack_n = 1;
          repeat (3) @(negedge clk);
          card_width_n = 0; card_audio_n = 0; card_inack_n = 0;
          @(negedge clk); #2;
          chk(host_dreq == 0, "R1 latency edge1", host_dreq, 0);
          @(negedge clk); #2;
          chk(host_dreq == 1, "R1 latency edge2", host_dreq, 1);
        end
      end
    end

    // R3-R6: strobe redefinition over all host and normal-pin combinations
    for (int s = 0; s < 4; s++) begin
      for (int io = 0; io < 2; io++) begin
        set_cfg(s[1:0], io[0]);
        for (int v = 0; v < 128; v++) begin
          logic cyc;
          logic er, eo, ew;
          @(negedge clk);
          host_dack = v[0]; host_tc = v[1]; host_ior_n = v[2]; host_iow_n = v[3];
          std_reg_n = v[4]; std_oe_n = v[5]; std_we_n = v[6];
          #2;
          cyc = (s != 0) && (io == 1) && v[0] && (!v[2] || !v[3]);
          er = cyc ? 1'b1 : v[4];
          eo = (cyc && !v[2]) ? !v[1] : v[5];
          ew = (cyc && !v[3]) ? !v[1] : v[6];
          chk(card_regsel_n == er, cyc ? "R3 ack" : "R6 regsel", card_regsel_n, er);
          chk(card_rdstb_n == eo, cyc ? "R4 rd tc" : "R6 rd normal", card_rdstb_n, eo);
          chk(card_wrstb_n == ew, cyc ? "R5 wr tc" : "R6 wr normal", card_wrstb_n, ew);
        end
        @(negedge clk);
        idle_host();
      end
    end

    // R7-R9: gating of borrowed pin functions per source
    for (int s = 0; s < 4; s++) begin
      set_cfg(s[1:0], 1'b1);
      for (int v = 0; v < 32; v++) begin
        logic [NWIN-1:0] ea;
        logic es, eu, ei;
        @(negedge clk);
        card_width_n = v[0]; std_stat4 = v[1]; std_audio = v[2];
        std_inack_ctl = v[3]; std_auto16 = {v[4], ~v[4]};
        #2;
        es = (s == 2) ? v[0] : v[1];
        ea = (s == 2) ? '0 : {v[4], ~v[4]};
        eu = (s == 3) ? 1'b0 : v[2];
        ei = (s == 1) ? 1'b0 : v[3];
        chk(stat4 == es, "R7 stat4", stat4, es);
        chk(auto16_eff == ea, "R7 auto16", auto16_eff, ea);
        chk(card_audio_out == eu, "R8 audio", card_audio_out, eu);
        chk(inack_ctl_eff == ei, "R9 inack ctl", inack_ctl_eff, ei);
      end
    end

    // R10: select rewritten in the middle of a DMA cycle
    set_cfg(2'b10, 1'b1);
    card_width_n = 0; std_stat4 = 1; std_audio = 1; std_auto16 = '1;
    @(negedge clk);
    host_dack = 1; host_ior_n = 0; host_tc = 1;
    @(negedge clk);
    cfg_req_sel = 2'b11;
    repeat (3) @(negedge clk);
    #2;
    chk(stat4 == 0, "R10 held stat4", stat4, 0);
    chk(card_audio_out == 1, "R10 held audio", card_audio_out, 1);
    chk(card_regsel_n == 1, "R10 ack kept", card_regsel_n, 1);
    chk(card_rdstb_n == 0 && card_wrstb_n == 1, "R10 tc on rd only", card_rdstb_n, 0);
    @(negedge clk);
    host_iow_n = 0;
    #2;
    chk(card_rdstb_n == 0 && card_wrstb_n == 0, "R4 R5 both strobes", card_wrstb_n, 0);
    @(negedge clk);
    idle_host();
    #2;
    chk(stat4 == 0, "R10 before edge", stat4, 0);
    @(negedge clk); #2;
    chk(stat4 == 1, "R10 switched stat4", stat4, 1);
    chk(card_audio_out == 0, "R10 switched audio", card_audio_out, 0);

    // R11: reset in mid-run clears the effective select and the request
    card_audio_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    #2;
    chk(host_dreq == 0, "R11 dreq reset", host_dreq, 0);
    chk(card_audio_out == 1, "R11 select off", card_audio_out, 1);
    @(negedge clk);
    rst_n = 1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule